// File: doc/BRIEF.md
# Serial Audio Bit-Clock and Channel-Select Generator

This block drives the timing of a two-channel serial audio link when the chip is the timing source. It divides the system clock to make a bit clock, keeps count of bit positions within each frame, and drives a channel-select level: low while the left word is on the line, high while the right word is. Transmit and receive channel logic run on the system clock, not on the bit clock. They use the single-cycle strobes from this block to mark each bit-clock edge, and the two boundary pulses to mark where each word starts.

Nothing runs until two separate enables are both set: a block enable and a clock enable. Clearing either one puts every output back in its idle state, and the next start begins a fresh frame. The bit clock's half-period, counted in system clocks, comes in on a plain input port. A two-bit word-size code sets how many bit clocks make up each half-frame. The total bit rate is therefore the sample rate times the half-frame length times two.

Top module: `sckWsGen`

## Requirements
- R1: While `blockEn` or `clkEn` is 0, `sckOut`, `sckRise`, `sckFall`, `wsOut`, `frameStart` and `rightStart` all stay 0. Setting only one of the two enables starts nothing.
- R2: At the first clock edge that samples either enable low, every output returns to 0 and all internal counts restart. The next enabled run then repeats exactly the sequence seen after reset.
- R3: Count the rising clock edges that sample both enables high from 1. `sckOut` toggles at every edge whose number is a multiple of `divHalf`+1, and its first toggle is to 1. The bit-clock period is therefore 2*(`divHalf`+1) system clocks.
- R4: `sckRise` is high for exactly the cycles in which `sckOut` has just turned 1, and `sckFall` for exactly those in which it has just turned 0. The two are never high together.
- R5: `resSel` sets the half-frame length H in bit clocks: 0 gives 16, 1 gives 24, and 2 or 3 give 32. A frame is 2H bit clocks long.
- R6: Number the bit-clock falling edges since enable from 1 and call that number f. After edge f, `wsOut` is 1 exactly when f mod 2H is at least H (0 = left, 1 = right). It changes only in a `sckFall` cycle, or when the block is disabled.
- R7: `frameStart` pulses for one cycle when `wsOut` turns from 1 to 0 at a falling edge, which is when f mod 2H equals 0. It never pulses on enable.
- R8: `rightStart` pulses for one cycle when `wsOut` turns from 0 to 1, which is when f mod 2H equals H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| blockEn | input | 1 | Global block enable |
| clkEn | input | 1 | Bit-clock enable |
| divHalf | input | DIV_W | Bit-clock half-period minus one, in system clocks |
| resSel | input | 2 | Half-frame length code |
| sckOut | output | 1 | Bit-clock level |
| sckRise | output | 1 | Strobe in the cycle the bit clock has risen |
| sckFall | output | 1 | Strobe in the cycle the bit clock has fallen |
| wsOut | output | 1 | Channel select, 0 = left, 1 = right |
| frameStart | output | 1 | One-cycle pulse at the start of the left word |
| rightStart | output | 1 | One-cycle pulse at the start of the right word |

## Verification
The assertions assume that `divHalf` and `resSel` hold steady while the block runs. With that assumption, the bit-clock and channel-select transitions follow only from strobes and from loss of enable. The stimulus changes the divider and the word-size code only while an enable is low, and it drives every input at the falling clock edge. Each enabled run is checked cycle by cycle against counts computed from the edge index. It is then stopped mid-frame, at a point that differs from run to run, to exercise the restart.

// File: rtl/sckWsPkg.sv
package sckWsPkg;
  localparam int MAX_HALF = 32;
  localparam int CNT_W    = $clog2(2 * MAX_HALF);

  typedef struct packed {
    logic run;       // both enables set this cycle
    logic fallTick;  // bit clock falls at this edge
  } clkStrobes_t;

  function automatic logic [CNT_W-1:0] halfLenOf(input logic [1:0] sel);
    case (sel)
      2'd0:    halfLenOf = CNT_W'(16);
      2'd1:    halfLenOf = CNT_W'(24);
      default: halfLenOf = CNT_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/sckCtrl.sv
module sckCtrl
  import sckWsPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             blockEn,
  input  logic             clkEn,
  input  logic [DIV_W-1:0] divHalf,
  output logic             sckOut,
  output logic             sckRise,
  output logic             sckFall,
  output clkStrobes_t      strobes
);
  logic [DIV_W-1:0] divCnt;
  logic             run;
  logic             divWrap;
  logic             toggle;

  assign run     = blockEn & clkEn;
  assign divWrap = (divCnt >= divHalf);
  assign toggle  = run && divWrap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      sckOut  <= 1'b0;
      sckRise <= 1'b0;
      sckFall <= 1'b0;
    end else if (!run) begin
      divCnt  <= '0;
      sckOut  <= 1'b0;
      sckRise <= 1'b0;
      sckFall <= 1'b0;
    end else begin
      divCnt  <= divWrap ? '0 : divCnt + 1'b1;
      if (toggle) sckOut <= ~sckOut;
      sckRise <= toggle && !sckOut;
      sckFall <= toggle && sckOut;
    end
  end

  assign strobes.run      = run;
  assign strobes.fallTick = toggle && sckOut;

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(blockEn && clkEn) |=> (!sckOut && !sckRise && !sckFall));

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(sckRise && sckFall));

  assert_rise_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    sckRise |-> (sckOut && !$past(sckOut)));

  assert_fall_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    sckFall |-> (!sckOut && $past(sckOut)));

  assert_sck_moves_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sckOut != $past(sckOut)) |-> (sckRise || sckFall || !$past(run)));
endmodule

// File: rtl/wsDatapath.sv
module wsDatapath
  import sckWsPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  resSel,
  input  clkStrobes_t strobes,
  output logic        wsOut,
  output logic        frameStart,
  output logic        rightStart
);
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] halfLen;
  logic [CNT_W:0]   lastIdx;
  logic             frameLast;
  logic [CNT_W-1:0] nextCnt;

  assign halfLen   = halfLenOf(resSel);
  assign lastIdx   = {halfLen, 1'b0} - 1'b1;
  assign frameLast = ({1'b0, bitCnt} >= lastIdx);
  assign nextCnt   = frameLast ? '0 : bitCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN || !strobes.run) begin
      bitCnt     <= '0;
      wsOut      <= 1'b0;
      frameStart <= 1'b0;
      rightStart <= 1'b0;
    end else if (strobes.fallTick) begin
      bitCnt     <= nextCnt;
      wsOut      <= (nextCnt >= halfLen);
      frameStart <= frameLast;
      rightStart <= (nextCnt == halfLen);
    end else begin
      frameStart <= 1'b0;
      rightStart <= 1'b0;
    end
  end

  assert_frame_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (!wsOut && $past(wsOut)));

  assert_right_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    rightStart |-> (wsOut && !$past(wsOut)));

  assert_pulse_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(frameStart && rightStart));
endmodule

// File: rtl/sckWsGen.sv
module sckWsGen
  import sckWsPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             blockEn,
  input  logic             clkEn,
  input  logic [DIV_W-1:0] divHalf,
  input  logic [1:0]       resSel,
  output logic             sckOut,
  output logic             sckRise,
  output logic             sckFall,
  output logic             wsOut,
  output logic             frameStart,
  output logic             rightStart
);
  clkStrobes_t strobes;

  sckCtrl #(.DIV_W(DIV_W)) i_sckCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .blockEn (blockEn),
    .clkEn   (clkEn),
    .divHalf (divHalf),
    .sckOut  (sckOut),
    .sckRise (sckRise),
    .sckFall (sckFall),
    .strobes (strobes)
  );

  wsDatapath i_wsDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .resSel     (resSel),
    .strobes    (strobes),
    .wsOut      (wsOut),
    .frameStart (frameStart),
    .rightStart (rightStart)
  );

  assert_ws_on_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wsOut != $past(wsOut)) |-> (sckFall || !$past(blockEn && clkEn)));

  assert_ws_low_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(blockEn && clkEn) |=> (!wsOut && !frameStart && !rightStart));
endmodule

// File: tb/test_sckWsGen.sv
`timescale 1ns/1ps
module test_sckWsGen;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic blockEn = 1'b0;
  logic clkEn = 1'b0;
  logic [DIV_W-1:0] divHalf = '0;
  logic [1:0] resSel = '0;
  logic sckOut, sckRise, sckFall, wsOut, frameStart, rightStart;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sckWsGen #(.DIV_W(DIV_W)) i_sckWsGen (
    .clk(clk), .rstN(rstN), .blockEn(blockEn), .clkEn(clkEn),
    .divHalf(divHalf), .resSel(resSel),
    .sckOut(sckOut), .sckRise(sckRise), .sckFall(sckFall),
    .wsOut(wsOut), .frameStart(frameStart), .rightStart(rightStart)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int packOut();
    return {26'd0, sckOut, sckRise, sckFall, wsOut, frameStart, rightStart};
  endfunction

  function automatic int halfOf(input int sel);
    return (sel == 0) ? 16 : (sel == 1) ? 24 : 32;
  endfunction

  // Run enabled for len cycles, comparing against arithmetic expectations.
  task automatic runCheck(input int n, input int sel, input int len);
    int h;
    h = halfOf(sel);
    blockEn = 1'b1;
    clkEn   = 1'b1;
    for (int k = 0; k < len; k++) begin
      int m, f, pos;
      bit tog, eSck, eRise, eFall, eWs, eFrame, eRight;
      @(negedge clk);
      m     = (k + 1) / (n + 1);
      tog   = ((k + 1) % (n + 1)) == 0;
      eSck  = (m % 2) == 1;
      eRise = tog && (m % 2 == 1);
      eFall = tog && (m % 2 == 0);
      f     = m / 2;
      pos   = f % (2 * h);
      eWs   = pos >= h;
      eFrame = eFall && (pos == 0);
      eRight = eFall && (pos == h);
      check($sformatf("R3 sck n=%0d sel=%0d k=%0d", n, sel, k), sckOut, eSck);
      check($sformatf("R4 strobes n=%0d sel=%0d k=%0d", n, sel, k),
            {sckRise, sckFall}, {eRise, eFall});
      check($sformatf("R5 R6 ws n=%0d sel=%0d k=%0d", n, sel, k), wsOut, eWs);
      check($sformatf("R7 R8 pulses n=%0d sel=%0d k=%0d", n, sel, k),
            {frameStart, rightStart}, {eFrame, eRight});
    end
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("reset state R1", packOut(), 0);
    rstN = 1'b1;

    // R1: one enable alone starts nothing
    blockEn = 1'b1; clkEn = 1'b0; divHalf = 8'd0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R1 blockEn only", packOut(), 0);
    end
    blockEn = 1'b0; clkEn = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R1 clkEn only", packOut(), 0);
    end
    clkEn = 1'b0;
    @(negedge clk);

    // Sweep divider and word-size codes; each run stops mid-frame (R2)
    for (int n = 0; n < 4; n++) begin
      for (int sel = 0; sel < 4; sel++) begin
        int len;
        divHalf = DIV_W'(n);
        resSel  = 2'(sel);
        len = 2 * (2 * halfOf(sel)) * 2 * (n + 1) + 7 + 3 * sel + n;
        runCheck(n, sel, len);
        if (((n + sel) % 2) == 0) clkEn = 1'b0; else blockEn = 1'b0;
        @(negedge clk);
        check($sformatf("R2 idle after stop n=%0d sel=%0d", n, sel), packOut(), 0);
        blockEn = 1'b0; clkEn = 1'b0;
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          check("R1 stays idle while disabled", packOut(), 0);
        end
      end
    end

    // R2: restart with identical settings replays the same sequence
    divHalf = 8'd1; resSel = 2'd0;
    runCheck(1, 0, 150);
    blockEn = 1'b0;
    @(negedge clk);
    check("R2 idle after mid-frame stop", packOut(), 0);
    runCheck(1, 0, 300);
    blockEn = 1'b0; clkEn = 1'b0;
    @(negedge clk);
    check("R2 final idle", packOut(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule